// File: doc/BRIEF.md
# Programmable I/O Cell

This block models one configurable pad cell of a programmable-logic fabric. Static configuration inputs decide how the cell behaves. On the input side the resolved pin level goes straight to the core and also into a storage element. That element works either as a rising-edge flip-flop or as a level-sensitive latch. On the output side the pad data comes either straight from the core or from an output register, and it can be inverted. A tri-state mode decides whether the driver is always on, always off, or follows a control input whose sense can be inverted.

Each storage element takes its clock from one of several clock lines. Every line passes through its own invert bit. A line set for rising-edge capture makes latches on it transparent while the line is low.

The pad is split into separate values: the level the cell drives, its drive enable, and the level an external agent drives. A pull-up resolves the case where nothing drives the pin. A soft-start sequencer holds the slow-slew flag high from configuration until the first active output cycle. Threshold, pull-up and slew are only reported as flag outputs.

Top module: `pio_cell`

## Requirements
- R1: While `rst_n` is low or `cfg_busy` is high, the stored input value reads 0 and the output register holds 0, so a registered pad output equals `cfg_out_inv`.
- R2: Each storage element uses clock line `clk_line[sel]`, XORed with `cfg_clk_inv[sel]`. A flip-flop captures only on a rising edge of that effective clock, and never on a falling one.
- R3: With `cfg_in_latch`=0, `core_i_stored` changes only at a rising edge of the effective input clock, and then takes the resolved pin level.
- R4: With `cfg_in_latch`=1, `core_i_stored` follows the resolved pin while the effective input clock is 0 and holds while it is 1.
- R5: `core_i_direct` is the resolved pin level, chosen in this priority order: `pad_out` when `pad_oe`=1; otherwise `pad_in` when `pad_ext_drv`=1; otherwise `cfg_pullup`.
- R6: With `cfg_out_reg`=0, `pad_out` follows `core_o` at once. With `cfg_out_reg`=1, it shows `core_o` as captured at the last rising edge of the effective output clock.
- R7: `cfg_out_inv`=1 inverts `pad_out` in both the direct and the registered source mode.
- R8: `cfg_tri_mode` sets the drive enable. 2'b00 drives always. 2'b01 and 2'b11 never drive. 2'b10 drives when `core_t ^ cfg_t_inv` is 0, so a 1 there means high impedance. `cfg_busy`=1 forces `pad_oe` to 0.
- R9: In mode 2'b10 with no inversion and direct output, tying `core_o` and `core_t` together gives open-drain behaviour: the pad is driven low for 0, and released for 1, when it reads as the pull-up level.
- R10: `pad_slow_slew` is 1 from `cfg_busy` until the first rising edge of `clk_line[0]` at which `pad_oe`=1 and `cfg_busy`=0. After that edge it equals `!cfg_fast_slew`. It is set again only by a new configuration, and not by `rst_n`.
- R11: `pad_pullup_on` mirrors `cfg_pullup` and `pad_ttl` mirrors `cfg_ttl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_line | input | NUM_CLK_LINES | Clock lines along the die edge |
| rst_n | input | 1 | Active-low chip reset of the storage elements |
| cfg_busy | input | 1 | High while configuration is loading |
| cfg_clk_inv | input | NUM_CLK_LINES | Per-line clock invert bits |
| cfg_in_clk_sel | input | SEL_W | Clock line for the input storage |
| cfg_out_clk_sel | input | SEL_W | Clock line for the output register |
| cfg_in_latch | input | 1 | 1: input storage is a latch, 0: flip-flop |
| cfg_out_reg | input | 1 | 1: pad driven from the output register |
| cfg_out_inv | input | 1 | Invert output data |
| cfg_tri_mode | input | 2 | Drive-enable mode |
| cfg_t_inv | input | 1 | Invert the tri-state control input |
| cfg_fast_slew | input | 1 | Per-pin fast slew select |
| cfg_pullup | input | 1 | Pull-up enable |
| cfg_ttl | input | 1 | Input threshold select |
| core_o | input | 1 | Output data from the core |
| core_t | input | 1 | Tri-state control from the core (1 = high impedance) |
| pad_in | input | 1 | Level driven by an external agent |
| pad_ext_drv | input | 1 | External agent is driving the pin |
| core_i_direct | output | 1 | Resolved pin level |
| core_i_stored | output | 1 | Captured pin level |
| pad_out | output | 1 | Level the cell drives |
| pad_oe | output | 1 | Cell drives the pin |
| pad_slow_slew | output | 1 | Slow slew flag |
| pad_pullup_on | output | 1 | Pull-up flag |
| pad_ttl | output | 1 | Threshold flag |

## Verification
The bound checker watches several relations at every clock edge. It checks that the disabled tri-state modes and configuration never enable the driver, and that an asserted control input disables it. It also checks that direct output tracks the inverted or plain core data, that tied data and control never drive a high level, and that stored data stays clear during configuration. It confirms that the slew flag obeys the per-pin bit once an active output cycle has passed. Only the bench scenarios can show edge and level timing: capture on the selected and inverted clock line, latch transparency against hold, register delay, and the pin-resolution priority. The same applies to the first-activation sequence in order, and to a second configuration rearming the soft start.

// File: rtl/pio_pkg.sv
package pio_pkg;

   typedef enum logic [1:0] {
      TRI_DRIVE   = 2'b00,
      TRI_HIZ     = 2'b01,
      TRI_CTRL    = 2'b10,
      TRI_HIZ_ALT = 2'b11
   } tri_mode_e;

   function automatic logic drive_enable(tri_mode_e mode, logic t_eff);
      logic en;
      case (mode)
         TRI_DRIVE: en = 1'b1;
         TRI_CTRL:  en = ~t_eff;
         default:   en = 1'b0;
      endcase
      return en;
   endfunction

endpackage

// File: rtl/pio_clk_bank.sv
module pio_clk_bank #(
   parameter int NUM_LINES = 2,
   localparam int SEL_W = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0] line,
   input  logic [NUM_LINES-1:0] inv,
   input  logic [SEL_W-1:0]     in_sel,
   input  logic [SEL_W-1:0]     out_sel,
   output logic                 in_clk,
   output logic                 out_clk
);

   logic [NUM_LINES-1:0] eff;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_buf
      assign eff[g] = line[g] ^ inv[g];
   end

   always_comb begin
      in_clk  = eff[0];
      out_clk = eff[0];
      for (int k = 1; k < NUM_LINES; k++) begin
         if (int'(in_sel) == k)  in_clk  = eff[k];
         if (int'(out_sel) == k) out_clk = eff[k];
      end
   end

endmodule

// File: rtl/pio_in_path.sv
module pio_in_path #(
   parameter bit LATCH_CAPABLE = 1'b1
) (
   input  logic eclk,
   input  logic clr,
   input  logic pin,
   input  logic use_latch,
   output logic stored
);

   logic ff_q;

   always_ff @(posedge eclk or posedge clr) begin
      if (clr) ff_q <= 1'b0;
      else     ff_q <= pin;
   end

   if (LATCH_CAPABLE) begin : g_latch
      logic lat_q;
      always_latch begin
         if (clr)        lat_q <= 1'b0;
         else if (!eclk) lat_q <= pin;
      end
      assign stored = use_latch ? lat_q : ff_q;
   end else begin : g_ff_only
      logic unused_sel;
      assign unused_sel = use_latch;
      assign stored     = ff_q;
   end

endmodule

// File: rtl/pio_out_path.sv
module pio_out_path
   import pio_pkg::*;
#(
   parameter bit REG_CAPABLE = 1'b1
) (
   input  logic       eclk,
   input  logic       clr,
   input  logic       busy,
   input  logic       core_o,
   input  logic       core_t,
   input  logic       use_reg,
   input  logic       out_inv,
   input  logic [1:0] tri_mode,
   input  logic       t_inv,
   output logic       pad_out,
   output logic       pad_oe
);

   logic data_sel;
   logic t_eff;

   if (REG_CAPABLE) begin : g_reg
      logic o_q;
      always_ff @(posedge eclk or posedge clr) begin
         if (clr) o_q <= 1'b0;
         else     o_q <= core_o;
      end
      assign data_sel = use_reg ? o_q : core_o;
   end else begin : g_direct_only
      logic unused_src;
      assign unused_src = use_reg ^ eclk ^ clr;
      assign data_sel   = core_o;
   end

   assign pad_out = data_sel ^ out_inv;
   assign t_eff   = core_t ^ t_inv;
   assign pad_oe  = ~busy & drive_enable(tri_mode_e'(tri_mode), t_eff);

endmodule

// File: rtl/pio_soft_start.sv
module pio_soft_start (
   input  logic clk,
   input  logic busy,
   input  logic oe,
   input  logic fast,
   output logic slow
);

   logic pending;

   always_ff @(posedge clk or posedge busy) begin
      if (busy)    pending <= 1'b1;
      else if (oe) pending <= 1'b0;
   end

   assign slow = pending | ~fast;

endmodule

// File: rtl/pio_cell.sv
module pio_cell #(
   parameter int NUM_CLK_LINES = 2,
   parameter bit IN_LATCH_EN   = 1'b1,
   parameter bit OUT_REG_EN    = 1'b1,
   localparam int SEL_W = $clog2(NUM_CLK_LINES)
) (
   input  logic [NUM_CLK_LINES-1:0] clk_line,
   input  logic                     rst_n,
   input  logic                     cfg_busy,
   input  logic [NUM_CLK_LINES-1:0] cfg_clk_inv,
   input  logic [SEL_W-1:0]         cfg_in_clk_sel,
   input  logic [SEL_W-1:0]         cfg_out_clk_sel,
   input  logic                     cfg_in_latch,
   input  logic                     cfg_out_reg,
   input  logic                     cfg_out_inv,
   input  logic [1:0]               cfg_tri_mode,
   input  logic                     cfg_t_inv,
   input  logic                     cfg_fast_slew,
   input  logic                     cfg_pullup,
   input  logic                     cfg_ttl,
   input  logic                     core_o,
   input  logic                     core_t,
   input  logic                     pad_in,
   input  logic                     pad_ext_drv,
   output logic                     core_i_direct,
   output logic                     core_i_stored,
   output logic                     pad_out,
   output logic                     pad_oe,
   output logic                     pad_slow_slew,
   output logic                     pad_pullup_on,
   output logic                     pad_ttl
);

   if (NUM_CLK_LINES < 2) begin : g_bad_lines
      $error("pio_cell: NUM_CLK_LINES must be at least 2");
   end

   logic in_clk;
   logic out_clk;
   logic clr;
   logic pin_level;

   assign clr = ~rst_n | cfg_busy;

   pio_clk_bank #(.NUM_LINES(NUM_CLK_LINES)) i_clk_bank (
      .line    (clk_line),
      .inv     (cfg_clk_inv),
      .in_sel  (cfg_in_clk_sel),
      .out_sel (cfg_out_clk_sel),
      .in_clk  (in_clk),
      .out_clk (out_clk)
   );

   pio_out_path #(.REG_CAPABLE(OUT_REG_EN)) i_out_path (
      .eclk     (out_clk),
      .clr      (clr),
      .busy     (cfg_busy),
      .core_o   (core_o),
      .core_t   (core_t),
      .use_reg  (cfg_out_reg),
      .out_inv  (cfg_out_inv),
      .tri_mode (cfg_tri_mode),
      .t_inv    (cfg_t_inv),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   // Pin resolution: own driver, then external agent, then pull-up.
   always_comb begin
      if (pad_oe)           pin_level = pad_out;
      else if (pad_ext_drv) pin_level = pad_in;
      else                  pin_level = cfg_pullup;
   end

   assign core_i_direct = pin_level;

   pio_in_path #(.LATCH_CAPABLE(IN_LATCH_EN)) i_in_path (
      .eclk      (in_clk),
      .clr       (clr),
      .pin       (pin_level),
      .use_latch (cfg_in_latch),
      .stored    (core_i_stored)
   );

   pio_soft_start i_soft_start (
      .clk  (clk_line[0]),
      .busy (cfg_busy),
      .oe   (pad_oe),
      .fast (cfg_fast_slew),
      .slow (pad_slow_slew)
   );

   assign pad_pullup_on = cfg_pullup;
   assign pad_ttl       = cfg_ttl;

endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk #(
   parameter int NUM_CLK_LINES = 2
) (
   input logic [NUM_CLK_LINES-1:0] clk_line,
   input logic       rst_n,
   input logic       cfg_busy,
   input logic       cfg_out_reg,
   input logic       cfg_out_inv,
   input logic [1:0] cfg_tri_mode,
   input logic       cfg_t_inv,
   input logic       cfg_fast_slew,
   input logic       core_o,
   input logic       core_t,
   input logic       core_i_stored,
   input logic       pad_out,
   input logic       pad_oe,
   input logic       pad_slow_slew
);

   logic ck;
   assign ck = clk_line[0];

   p_hiz_mode_r8: assert property (@(posedge ck) disable iff (!rst_n)
      (cfg_tri_mode == 2'b01 || cfg_tri_mode == 2'b11) |-> !pad_oe);

   p_ctrl_hiz_r8: assert property (@(posedge ck) disable iff (!rst_n)
      (cfg_tri_mode == 2'b10 && (core_t != cfg_t_inv)) |-> !pad_oe);

   p_busy_idle_r8: assert property (@(posedge ck) disable iff (!rst_n)
      cfg_busy |-> !pad_oe);

   p_direct_out_r7: assert property (@(posedge ck) disable iff (!rst_n)
      !cfg_out_reg |-> (pad_out == (core_o ^ cfg_out_inv)));

   p_open_drain_r9: assert property (@(posedge ck) disable iff (!rst_n)
      (cfg_tri_mode == 2'b10 && !cfg_t_inv && !cfg_out_reg && !cfg_out_inv
       && (core_o == core_t) && !cfg_busy) |-> (!pad_oe || !pad_out));

   p_busy_slow_r10: assert property (@(posedge ck) disable iff (!rst_n)
      cfg_busy |-> pad_slow_slew);

   p_soft_done_r10: assert property (@(posedge ck) disable iff (!rst_n)
      (!cfg_busy && $past(pad_oe && !cfg_busy)) |-> (pad_slow_slew == !cfg_fast_slew));

   p_stored_clear_r1: assert property (@(posedge ck) disable iff (!rst_n)
      cfg_busy |-> !core_i_stored);

endmodule

bind pio_cell pio_cell_chk #(.NUM_CLK_LINES(NUM_CLK_LINES)) i_chk (.*);

// File: tb/test_pio_cell.sv
module test_pio_cell;

   logic       clk = 1'b0;
   logic       clk_b = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_busy = 1'b1;
   logic [1:0] cfg_clk_inv = 2'b00;
   logic       cfg_in_clk_sel = 1'b0;
   logic       cfg_out_clk_sel = 1'b0;
   logic       cfg_in_latch = 1'b0;
   logic       cfg_out_reg = 1'b0;
   logic       cfg_out_inv = 1'b0;
   logic [1:0] cfg_tri_mode = 2'b00;
   logic       cfg_t_inv = 1'b0;
   logic       cfg_fast_slew = 1'b1;
   logic       cfg_pullup = 1'b1;
   logic       cfg_ttl = 1'b0;
   logic       core_o = 1'b0;
   logic       core_t = 1'b0;
   logic       pad_in = 1'b0;
   logic       pad_ext_drv = 1'b0;
   logic       core_i_direct, core_i_stored, pad_out, pad_oe;
   logic       pad_slow_slew, pad_pullup_on, pad_ttl;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   localparam int S_DIR = 0, S_STO = 1, S_OUT = 2, S_OE = 3, S_SLOW = 4, S_PU = 5, S_TTL = 6;

   typedef struct {
      string req;
      int    sig;
      logic  val;
   } item_t;

   item_t sbq[$];

   always #4 clk = ~clk;

   pio_cell i_pio_cell (
      .clk_line        ({clk_b, clk}),
      .rst_n           (rst_n),
      .cfg_busy        (cfg_busy),
      .cfg_clk_inv     (cfg_clk_inv),
      .cfg_in_clk_sel  (cfg_in_clk_sel),
      .cfg_out_clk_sel (cfg_out_clk_sel),
      .cfg_in_latch    (cfg_in_latch),
      .cfg_out_reg     (cfg_out_reg),
      .cfg_out_inv     (cfg_out_inv),
      .cfg_tri_mode    (cfg_tri_mode),
      .cfg_t_inv       (cfg_t_inv),
      .cfg_fast_slew   (cfg_fast_slew),
      .cfg_pullup      (cfg_pullup),
      .cfg_ttl         (cfg_ttl),
      .core_o          (core_o),
      .core_t          (core_t),
      .pad_in          (pad_in),
      .pad_ext_drv     (pad_ext_drv),
      .core_i_direct   (core_i_direct),
      .core_i_stored   (core_i_stored),
      .pad_out         (pad_out),
      .pad_oe          (pad_oe),
      .pad_slow_slew   (pad_slow_slew),
      .pad_pullup_on   (pad_pullup_on),
      .pad_ttl         (pad_ttl)
   );

   function automatic logic pick(int s);
      case (s)
         S_DIR:   return core_i_direct;
         S_STO:   return core_i_stored;
         S_OUT:   return pad_out;
         S_OE:    return pad_oe;
         S_SLOW:  return pad_slow_slew;
         S_PU:    return pad_pullup_on;
         default: return pad_ttl;
      endcase
   endfunction

   // Driver side: queue an expected value for the coming sample point.
   task automatic expect_on(string req, int s, logic v);
      item_t it;
      it.req = req;
      it.sig = s;
      it.val = v;
      sbq.push_back(it);
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   // Monitor side: compare queued items 3 ns after each rising edge.
   always @(posedge clk) begin
      #3;
      while (sbq.size() > 0) begin
         item_t it;
         logic  act;
         it  = sbq.pop_front();
         act = pick(it.sig);
         n_chk++;
         if (act !== it.val) begin
            n_fail++;
            $display("FAIL %s signal %0d actual %b expected %b at %0t", it.req, it.sig, act, it.val, $time);
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // configuration phase
      step();
      expect_on("R1", S_STO, 1'b0);
      expect_on("R8", S_OE, 1'b0);
      expect_on("R10", S_SLOW, 1'b1);
      expect_on("R11", S_PU, 1'b1);
      expect_on("R11", S_TTL, 1'b0);
      // user mode, driver disabled, pin floating
      step();
      cfg_ttl = 1'b1; rst_n = 1'b1; cfg_busy = 1'b0; cfg_tri_mode = 2'b01;
      expect_on("R11", S_TTL, 1'b1);
      expect_on("R8", S_OE, 1'b0);
      expect_on("R10", S_SLOW, 1'b1);
      expect_on("R5", S_DIR, 1'b1);
      step();
      cfg_pullup = 1'b0;
      expect_on("R5", S_DIR, 1'b0);
      expect_on("R11", S_PU, 1'b0);
      step();
      cfg_pullup = 1'b1; pad_ext_drv = 1'b1; pad_in = 1'b0;
      expect_on("R5", S_DIR, 1'b0);
      expect_on("R10", S_SLOW, 1'b1);
      // R3: input flip-flop on line 0
      step();
      pad_in = 1'b1;
      expect_on("R3", S_STO, 1'b0);
      expect_on("R5", S_DIR, 1'b1);
      step();
      expect_on("R3", S_STO, 1'b1);
      // R4: latch mode
      step();
      cfg_in_latch = 1'b1; pad_in = 1'b0;
      expect_on("R4", S_STO, 1'b1);
      step();
      expect_on("R4", S_STO, 1'b0);
      step();
      clk_b = 1'b1; cfg_in_clk_sel = 1'b1; pad_in = 1'b1;
      expect_on("R4", S_STO, 1'b0);
      step();
      clk_b = 1'b0;
      expect_on("R4", S_STO, 1'b1);
      step();
      clk_b = 1'b1;
      expect_on("R4", S_STO, 1'b1);
      step();
      pad_in = 1'b0;
      expect_on("R4", S_STO, 1'b1);
      // R2: flip-flop on inverted line 1
      step();
      rst_n = 1'b0; cfg_in_latch = 1'b0; cfg_clk_inv = 2'b10; pad_in = 1'b1;
      expect_on("R1", S_STO, 1'b0);
      step();
      rst_n = 1'b1;
      expect_on("R2", S_STO, 1'b0);
      step();
      expect_on("R2", S_STO, 1'b0);
      step();
      clk_b = 1'b0;
      expect_on("R2", S_STO, 1'b1);
      step();
      clk_b = 1'b1; pad_in = 1'b0;
      expect_on("R2", S_STO, 1'b1);
      // R6/R7: output source and inversion
      step();
      core_o = 1'b1;
      expect_on("R6", S_OUT, 1'b1);
      step();
      cfg_out_inv = 1'b1;
      expect_on("R7", S_OUT, 1'b0);
      step();
      cfg_out_inv = 1'b0; cfg_out_reg = 1'b1; core_o = 1'b0;
      expect_on("R6", S_OUT, 1'b1);
      step();
      expect_on("R6", S_OUT, 1'b0);
      step();
      cfg_out_inv = 1'b1;
      expect_on("R7", S_OUT, 1'b1);
      step();
      core_o = 1'b1; rst_n = 1'b0; cfg_out_inv = 1'b0;
      expect_on("R1", S_OUT, 1'b0);
      step();
      expect_on("R1", S_OUT, 1'b0);
      step();
      rst_n = 1'b1;
      expect_on("R6", S_OUT, 1'b0);
      step();
      expect_on("R6", S_OUT, 1'b1);
      // R8/R10: tri-state modes and soft start
      step();
      cfg_tri_mode = 2'b10; cfg_t_inv = 1'b0; core_t = 1'b1;
      expect_on("R10", S_SLOW, 1'b1);
      expect_on("R8", S_OE, 1'b0);
      step();
      core_t = 1'b0;
      expect_on("R8", S_OE, 1'b1);
      expect_on("R10", S_SLOW, 1'b1);
      step();
      core_t = 1'b1;
      expect_on("R10", S_SLOW, 1'b0);
      expect_on("R8", S_OE, 1'b0);
      step();
      cfg_t_inv = 1'b1;
      expect_on("R8", S_OE, 1'b1);
      expect_on("R10", S_SLOW, 1'b0);
      step();
      cfg_tri_mode = 2'b00; cfg_t_inv = 1'b0; cfg_fast_slew = 1'b0;
      expect_on("R8", S_OE, 1'b1);
      expect_on("R10", S_SLOW, 1'b1);
      step();
      cfg_tri_mode = 2'b11; cfg_fast_slew = 1'b1;
      expect_on("R8", S_OE, 1'b0);
      expect_on("R10", S_SLOW, 1'b0);
      // R5: own driver wins over external agent
      step();
      cfg_tri_mode = 2'b00; cfg_out_reg = 1'b0; core_o = 1'b0; pad_ext_drv = 1'b1; pad_in = 1'b1;
      expect_on("R5", S_DIR, 1'b0);
      expect_on("R6", S_OUT, 1'b0);
      // R9: open drain
      step();
      cfg_tri_mode = 2'b10; core_o = 1'b0; core_t = 1'b0; pad_ext_drv = 1'b0;
      expect_on("R9", S_OE, 1'b1);
      expect_on("R9", S_OUT, 1'b0);
      expect_on("R9", S_DIR, 1'b0);
      step();
      core_o = 1'b1; core_t = 1'b1;
      expect_on("R9", S_OE, 1'b0);
      expect_on("R9", S_DIR, 1'b1);
      // R10: a new configuration rearms the soft start
      step();
      cfg_busy = 1'b1;
      expect_on("R8", S_OE, 1'b0);
      expect_on("R10", S_SLOW, 1'b1);
      expect_on("R1", S_STO, 1'b0);
      step();
      cfg_busy = 1'b0; cfg_tri_mode = 2'b01;
      expect_on("R10", S_SLOW, 1'b1);
      step();
      expect_on("R10", S_SLOW, 1'b1);
      step();
      step();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule